// File: doc/BRIEF.md
# Dual-Mode Window Watchdog Supervisor

This block watches an external controller and decides whether it may keep its power stage enabled. Every watchdog sequence has a closed window followed by an open window, each lasting a programmable number of clock cycles. The controller proves that it is alive in one of two ways, chosen by a mode input. In pulse mode it toggles a trigger pin, and the rising edge must land in the open window. In question mode it writes four answer bytes that it derives from a 4-bit question the block publishes. The bytes must be correct, must come in descending index order, and the last one must land in the open window.

Each sequence ends in a good event or a bad event. A time-out at the end of the open window counts as a bad event. A saturating 3-bit failure counter steps down on good events and up on bad ones. The counter gates the drive-enable output. A bad event that arrives while the counter is already at its maximum can request a reset of the controller through an active-low output. Answer writes enter through a valid/ready port. That port never applies back-pressure, so the writer may treat every cycle with `ans_valid` high as an accepted byte. Other traffic on the controller's register bus never reaches this port and has no influence. The question output is steady between good events, so the controller may read it as often as it likes.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises: `fail_cnt` equals FAIL_INIT (5), `question` equals Q_SEED (4'h1), `drv_en` is 0, `rst_req_n` is 1, and `ans_ready` is 1 at all times out of reset.
- R2: A sequence starts with `win1_len` closed cycles followed by `win2_len` open cycles. If no event occurs, the last open cycle produces a time-out, which is a bad event. Any event makes the next cycle the first closed cycle of a new sequence.
- R3: With `qa_mode` at 0, a rising edge of `trig_in` is a good event in an open cycle and a bad event in a closed cycle. A rising edge means the pin was low at the previous clock edge and is high at this one. Answer writes have no effect in this mode.
- R4: With `qa_mode` at 1, the expected byte for index k (k = 3, 2, 1, 0, in that order) is {question ^ k, ~question ^ k}: the upper nibble is question XOR k and the lower nibble is inverted question XOR k. Four correct bytes in that order, with the index-0 byte written in an open cycle, form a good event. Bytes 3 to 1 may arrive in either window, with any gaps between them.
- R5: With `qa_mode` at 1, each of the following is a bad event at once: a byte that differs from the expected byte for the current index (this includes a byte out of order or a repeated byte), or a correct index-0 byte written in a closed cycle. Trigger edges have no effect in this mode. Every event resets the expected index to 3.
- R6: A good event in question mode replaces `question` with {question[2:0], question[3]^question[2]}, which is the LFSR x^4+x^3+1. Bad events, time-outs and pulse-mode events leave `question` unchanged.
- R7: A good event decrements `fail_cnt` and saturates at 0. A bad event increments it and saturates at 7. The new value is visible in the cycle after the event.
- R8: `drv_en` is registered. After each clock edge it equals `drv_req` AND (the updated failure count < 5).
- R9: A bad event while `fail_cnt` is 7 and `rst_en` is 1 drives `rst_req_n` low for exactly RST_LEN (4) cycles, starting in the cycle after the event. With `rst_en` at 0, the same event leaves `rst_req_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qa_mode | input | 1 | 0 = trigger-pulse mode, 1 = question/answer mode |
| trig_in | input | 1 | Trigger pin from the controller |
| ans_valid | input | 1 | Answer byte valid |
| ans_data | input | 8 | Answer byte |
| ans_ready | output | 1 | Answer port ready (always 1 out of reset) |
| drv_req | input | 1 | Controller's request to enable the drive output |
| rst_en | input | 1 | Allow a reset request on counter overflow |
| win1_len | input | WIN_W | Closed-window length in cycles |
| win2_len | input | WIN_W | Open-window length in cycles |
| question | output | 4 | Current question |
| fail_cnt | output | 3 | Failure counter |
| drv_en | output | 1 | Gated drive-enable output |
| rst_req_n | output | 1 | Active-low reset request to the controller |

## Verification
The bench steps through many window-length pairs and every trigger offset, and a window counter that is off by one cycle turns an expected good event into a bad one. That error shows in `fail_cnt` and `drv_en` in the very next cycle. A wrong answer index or a wrong question register shows up on the same schedule, because the following answer sequence fails and `question` stops advancing. A failure counter that wraps instead of saturating shows as a jump from 7 to 0, or from 0 to 7, right after the event. A broken overflow path shows either as `rst_req_n` staying high or as a low pulse of the wrong length.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  localparam int Q_W = 4;

  // expected answer byte for index k of question q
  function automatic logic [7:0] qa_expect(input logic [Q_W-1:0] q, input logic [1:0] k);
    logic [Q_W-1:0] kx;
    kx = {2'b00, k};
    return {q ^ kx, (~q) ^ kx};
  endfunction

  // one step of x^4 + x^3 + 1
  function automatic logic [Q_W-1:0] q_step(input logic [Q_W-1:0] q);
    return {q[2:0], q[3] ^ q[2]};
  endfunction

endpackage

// File: rtl/wdsup_window.sv
module wdsup_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [WIN_W-1:0] win1_len,
  input  logic [WIN_W-1:0] win2_len,
  output logic             win_open,
  output logic             timeout
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W:0]   cnt_inc;
  logic             open_q;
  logic             end_closed;
  logic             end_open;

  assign cnt_inc    = {1'b0, cnt_q} + (WIN_W+1)'(1);
  assign end_closed = !open_q && (cnt_inc >= {1'b0, win1_len});
  assign end_open   =  open_q && (cnt_inc >= {1'b0, win2_len});
  assign timeout    = end_open;
  assign win_open   = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (restart) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (end_closed) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_inc[WIN_W-1:0];
    end
  end
endmodule

// File: rtl/wdsup_trig.sv
module wdsup_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trig_in,
  input  logic win_open,
  output logic good,
  output logic bad
);
  logic trig_q;
  logic rise;

  assign rise = trig_in && !trig_q;
  assign good = enable && rise && win_open;
  assign bad  = enable && rise && !win_open;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b1;
    else        trig_q <= trig_in;
  end
endmodule

// File: rtl/wdsup_qa.sv
module wdsup_qa
  import wdsup_pkg::*;
#(
  parameter logic [Q_W-1:0] Q_SEED = 4'h1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           ans_valid,
  input  logic [7:0]     ans_data,
  input  logic           win_open,
  input  logic           seq_end,
  output logic [Q_W-1:0] question,
  output logic           good,
  output logic           bad
);
  logic [1:0]     idx_q;
  logic [Q_W-1:0] q_q;
  logic           take;
  logic           hit;
  logic           last;

  assign take     = enable && ans_valid;
  assign hit      = (ans_data == qa_expect(q_q, idx_q));
  assign last     = (idx_q == 2'd0);
  assign good     = take && hit && last && win_open;
  assign bad      = take && (!hit || (last && !win_open));
  assign question = q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 2'd3;
      q_q   <= Q_SEED;
    end else begin
      if (seq_end)          idx_q <= 2'd3;
      else if (take && hit) idx_q <= idx_q - 2'd1;
      if (good)             q_q   <= q_step(q_q);
    end
  end
endmodule

// File: rtl/wdsup_fail.sv
module wdsup_fail #(
  parameter int CNT_W     = 3,
  parameter int FAIL_INIT = 5,
  parameter int DRV_LIMIT = 5,
  parameter int RST_LEN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             good,
  input  logic             bad,
  input  logic             drv_req,
  input  logic             rst_en,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             drv_en,
  output logic             rst_req_n
);
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam int               RST_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] fail_q;
  logic [CNT_W-1:0] fail_nxt;
  logic             ovf;
  logic [RST_W-1:0] rcnt_q;
  logic             drv_q;

  always_comb begin
    fail_nxt = fail_q;
    ovf      = 1'b0;
    if (good) begin
      if (fail_q != '0) fail_nxt = fail_q - CNT_W'(1);
    end else if (bad) begin
      if (fail_q != CMAX) fail_nxt = fail_q + CNT_W'(1);
      else                ovf      = rst_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_q <= CNT_W'(FAIL_INIT);
      drv_q  <= 1'b0;
      rcnt_q <= '0;
    end else begin
      fail_q <= fail_nxt;
      drv_q  <= drv_req && (fail_nxt < CNT_W'(DRV_LIMIT));
      if (ovf)               rcnt_q <= RST_W'(RST_LEN);
      else if (rcnt_q != '0) rcnt_q <= rcnt_q - RST_W'(1);
    end
  end

  assign fail_cnt  = fail_q;
  assign drv_en    = drv_q;
  assign rst_req_n = (rcnt_q == '0);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdsup_pkg::*;
#(
  parameter int              WIN_W     = 8,
  parameter int              CNT_W     = 3,
  parameter int              FAIL_INIT = 5,
  parameter int              DRV_LIMIT = 5,
  parameter int              RST_LEN   = 4,
  parameter logic [Q_W-1:0]  Q_SEED    = 4'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qa_mode,
  input  logic             trig_in,
  input  logic             ans_valid,
  input  logic [7:0]       ans_data,
  output logic             ans_ready,
  input  logic             drv_req,
  input  logic             rst_en,
  input  logic [WIN_W-1:0] win1_len,
  input  logic [WIN_W-1:0] win2_len,
  output logic [Q_W-1:0]   question,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             drv_en,
  output logic             rst_req_n
);
  logic win_open, timeout;
  logic t_good, t_bad, a_good, a_bad;
  logic ev_good, ev_bad;

  assign ev_good   = t_good || a_good;
  assign ev_bad    = t_bad || a_bad || (timeout && !ev_good);
  assign ans_ready = 1'b1;

  wdsup_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(ev_good || ev_bad),
    .win1_len(win1_len), .win2_len(win2_len),
    .win_open(win_open), .timeout(timeout)
  );

  wdsup_trig u_trig (
    .clk(clk), .rst_n(rst_n), .enable(!qa_mode), .trig_in(trig_in),
    .win_open(win_open), .good(t_good), .bad(t_bad)
  );

  wdsup_qa #(.Q_SEED(Q_SEED)) u_qa (
    .clk(clk), .rst_n(rst_n), .enable(qa_mode), .ans_valid(ans_valid),
    .ans_data(ans_data), .win_open(win_open), .seq_end(ev_good || ev_bad),
    .question(question), .good(a_good), .bad(a_bad)
  );

  wdsup_fail #(
    .CNT_W(CNT_W), .FAIL_INIT(FAIL_INIT), .DRV_LIMIT(DRV_LIMIT), .RST_LEN(RST_LEN)
  ) u_fail (
    .clk(clk), .rst_n(rst_n), .good(ev_good), .bad(ev_bad),
    .drv_req(drv_req), .rst_en(rst_en),
    .fail_cnt(fail_cnt), .drv_en(drv_en), .rst_req_n(rst_req_n)
  );
endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker #(
  parameter int CNT_W     = 3,
  parameter int DRV_LIMIT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             qa_mode,
  input logic             rst_en,
  input logic [3:0]       question,
  input logic [CNT_W-1:0] fail_cnt,
  input logic             drv_en,
  input logic             rst_req_n
);
  // R7: the counter moves by at most one step and never wraps
  assert_fail_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt != $past(fail_cnt)) |->
      ((int'(fail_cnt) - int'($past(fail_cnt)) == 1) ||
       (int'($past(fail_cnt)) - int'(fail_cnt) == 1)));

  // R8: drive enable only below the threshold
  assert_drv_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (int'(fail_cnt) < DRV_LIMIT));

  // R9: reset request only from a saturated counter with reset allowed
  assert_rst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_n) |-> (($past(fail_cnt) == {CNT_W{1'b1}}) && $past(rst_en)));

  // R6: question moves only in question mode
  assert_q_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(question) |-> $past(qa_mode));

  // R6: the question never reaches the LFSR lock-up value
  assert_q_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (question != 4'h0));
endmodule

bind wdog_supervisor wdsup_checker #(.CNT_W(CNT_W), .DRV_LIMIT(DRV_LIMIT)) i_chk (
  .clk(clk), .rst_n(rst_n), .qa_mode(qa_mode), .rst_en(rst_en),
  .question(question), .fail_cnt(fail_cnt), .drv_en(drv_en), .rst_req_n(rst_req_n)
);

// File: tb/test_wdog_supervisor.sv
`timescale 1ns/1ps
module test_wdog_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       qa_mode = 1'b0, trig_in = 1'b0, ans_valid = 1'b0;
  logic [7:0] ans_data = 8'h00;
  logic       drv_req = 1'b1, rst_en = 1'b0;
  logic [7:0] win1_len = 8'd4, win2_len = 8'd4;
  logic       ans_ready, drv_en, rst_req_n;
  logic [3:0] question;
  logic [2:0] fail_cnt;

  int n_cmp = 0, n_mis = 0;
  int exp_fail = 5;
  int exp_q = 1;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_supervisor i_wdog_supervisor (
    .clk(clk), .rst_n(rst_n), .qa_mode(qa_mode), .trig_in(trig_in),
    .ans_valid(ans_valid), .ans_data(ans_data), .ans_ready(ans_ready),
    .drv_req(drv_req), .rst_en(rst_en), .win1_len(win1_len), .win2_len(win2_len),
    .question(question), .fail_cnt(fail_cnt), .drv_en(drv_en), .rst_req_n(rst_req_n)
  );

  function automatic int ans_of(input int q, input int k);
    return (((q ^ k) & 15) << 4) | (((~q) ^ k) & 15);
  endfunction

  function automatic int lfsr_of(input int q);
    return ((q << 1) & 14) | (((q >> 3) ^ (q >> 2)) & 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ev(input bit good);
    if (good) exp_fail = (exp_fail > 0) ? exp_fail - 1 : 0;
    else      exp_fail = (exp_fail < 7) ? exp_fail + 1 : 7;
  endtask

  task automatic check_state(input string req);
    chk(req, "fail_cnt", int'(fail_cnt), exp_fail);
    chk(req, "question", int'(question), exp_q);
    chk(req, "drv_en", int'(drv_en), (drv_req && exp_fail < 5) ? 1 : 0);
    chk(req, "rst_req_n", int'(rst_req_n), 1);
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic write_ans(input int b);
    ans_valid = 1'b1;
    ans_data  = 8'(b);
    @(negedge clk);
    ans_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    chk("R1", "fail_cnt in reset", int'(fail_cnt), 5);
    chk("R1", "rst_req_n in reset", int'(rst_req_n), 1);
    rst_n = 1'b1;
    #1;
    chk("R1", "fail_cnt", int'(fail_cnt), 5);
    chk("R1", "question", int'(question), 1);
    chk("R1", "drv_en", int'(drv_en), 0);
    chk("R1", "ans_ready", int'(ans_ready), 1);
    chk("R1", "rst_req_n", int'(rst_req_n), 1);

    // R3 / R2 / R8: every trigger offset over several window pairs
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        int l1, l2;
        l1 = (a == 0) ? 2 : (a == 1) ? 3 : 5;
        l2 = (b == 0) ? 1 : (b == 1) ? 2 : 4;
        win1_len = 8'(l1);
        win2_len = 8'(l2);
        for (int d = 1; d < l1 + l2; d++) begin
          repeat (d) @(negedge clk);
          pulse_trig();
          ev(d >= l1);
          check_state((d >= l1) ? "R3 open-window trigger" : "R3 closed-window trigger R7 R9");
        end
        // R2: time-out after l1+l2 quiet cycles
        repeat (l1 + l2) @(negedge clk);
        ev(1'b0);
        check_state("R2 time-out");
      end
    end

    // R3: answer writes ignored in trigger mode
    win1_len = 8'd4; win2_len = 8'd4;
    write_ans(ans_of(exp_q, 3));
    write_ans(8'h5a);
    write_ans(8'h00);
    check_state("R3 answers ignored");
    @(negedge clk);
    pulse_trig();
    ev(1'b1);
    check_state("R3 good after ignored answers");

    // R4 / R5 / R6: answer-0 at every offset, closed 5 open 4
    qa_mode = 1'b1;
    win1_len = 8'd5; win2_len = 8'd4;
    for (int w = 0; w <= 5; w++) begin
      write_ans(ans_of(exp_q, 3));
      write_ans(ans_of(exp_q, 2));
      write_ans(ans_of(exp_q, 1));
      repeat (w) @(negedge clk);
      write_ans(ans_of(exp_q, 0));
      ev(3 + w >= 5);
      if (3 + w >= 5) exp_q = lfsr_of(exp_q);
      check_state((3 + w >= 5) ? "R4 R6 good answer set" : "R5 answer-0 in closed window");
    end

    // R4 / R5: gaps and an ignored trigger edge between answers
    write_ans(ans_of(exp_q, 3));
    @(negedge clk);
    pulse_trig();
    write_ans(ans_of(exp_q, 2));
    check_state("R5 trigger ignored in question mode");
    write_ans(ans_of(exp_q, 1));
    @(negedge clk);
    write_ans(ans_of(exp_q, 0));
    ev(1'b1);
    exp_q = lfsr_of(exp_q);
    check_state("R4 answers with gaps");

    // R5: wrong byte, out of order, repeated byte
    write_ans(ans_of(exp_q, 3) ^ 8'h01);
    ev(1'b0);
    check_state("R5 wrong byte R6 question kept");
    write_ans(ans_of(exp_q, 2));
    ev(1'b0);
    check_state("R5 out of order");
    write_ans(ans_of(exp_q, 3));
    write_ans(ans_of(exp_q, 3));
    ev(1'b0);
    check_state("R5 repeated byte");

    // R2 / R6: time-out in question mode, then the index restarts at 3
    write_ans(ans_of(exp_q, 3));
    write_ans(ans_of(exp_q, 2));
    write_ans(ans_of(exp_q, 1));
    repeat (6) @(negedge clk);
    ev(1'b0);
    check_state("R2 R6 time-out keeps question");
    for (int k = 3; k >= 0; k--) begin
      if (k == 0) repeat (2) @(negedge clk);
      write_ans(ans_of(exp_q, k));
    end
    ev(1'b1);
    exp_q = lfsr_of(exp_q);
    check_state("R5 index reset after event");

    // R9: overflow with reset allowed
    qa_mode = 1'b0;
    win1_len = 8'd4; win2_len = 8'd4;
    rst_en = 1'b1;
    while (exp_fail < 7) begin
      @(negedge clk);
      pulse_trig();
      ev(1'b0);
    end
    check_state("R7 counter at 7");
    @(negedge clk);
    pulse_trig();
    chk("R9", "rst_req_n cycle 0", int'(rst_req_n), 0);
    chk("R7", "fail_cnt saturated", int'(fail_cnt), 7);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk("R9", "rst_req_n held low", int'(rst_req_n), 0);
    end
    @(negedge clk);
    chk("R9", "rst_req_n released", int'(rst_req_n), 1);
    rst_en = 1'b0;

    // R7 / R8: good events down to and past zero (sequence now at index 4)
    pulse_trig();
    ev(1'b1);
    check_state("R7 first good after reset pulse");
    for (int i = 0; i < 8; i++) begin
      repeat (4) @(negedge clk);
      pulse_trig();
      ev(1'b1);
      check_state("R7 R8 good event");
    end
    drv_req = 1'b0;
    @(negedge clk);
    chk("R8", "drv_en with request low", int'(drv_en), 0);
    drv_req = 1'b1;
    @(negedge clk);
    chk("R8", "drv_en with request high", int'(drv_en), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule